// File: doc/BRIEF.md
# Merging Write Buffer

This block sits between a write-through cache and the memory port and absorbs processor stores so that the processor keeps running while writes wait for memory. Each slot holds one block-aligned tag, a block of several 32-bit words and a byte-granular written mask. A store whose block already sits in a slot that is not being drained is folded into that slot. Any other store claims the next free slot. Memory therefore receives fewer write transactions, each of them wider.

Slots leave through a valid/ready port, oldest first, each as one block-wide write. That write carries a byte mask and a word mask, so memory updates only the bytes that were stored. The slot offered on that port is frozen: a new store to its block opens a fresh slot. A combinational lookup port lets a read check the buffer before going to memory. It returns buffered data when the newest slot holding bytes of the requested word holds all four of them. It raises a wait flag when that slot holds only some of them.

Top module: `merge_wbuf`

## Requirements
- R1: After reset the buffer is empty: `st_ready` is 1, `mem_valid` is 0, and `rd_hit` and `rd_wait` are 0.
- R2: A store to a block with no mergeable slot opens a new slot. Its drain presents `mem_addr` with the low log2(WORDS*4) bits cleared. Only the stored bytes are set, and all other bytes of the block read as zero.
- R3: A store whose block matches a live slot other than the one offered on the memory port merges into that slot. Stores to all words of one block leave as a single drain. A later store overwrites exactly the bytes selected by its `st_be`.
- R4: A store whose block matches only the slot currently offered on the memory port does not change that slot. It opens a new slot that drains afterwards.
- R5: Slots drain in arrival order. While `mem_valid` is 1 and `mem_ready` is 0, `mem_addr`, `mem_data` and `mem_bmask` hold their values. After the last slot drains, `mem_valid` is 0.
- R6: In a drain, word w of the block sits at `mem_data[32w+31:32w]`. Its byte b is marked in `mem_bmask[4w+b]`, and `st_be[b]` selects `st_data[8b+7:8b]`. `mem_wmask[w]` is 1 exactly when any byte of word w was stored.
- R7: When all slots are live, `st_ready` is 0 for a store that matches no mergeable slot, and the slot on the memory port does not change. A store that matches a mergeable slot is still accepted. An empty buffer never stalls a store.
- R8: A read whose word is fully present in the newest slot holding bytes of that word gives `rd_hit`=1, with `rd_data` taken from that slot. A word absent from the buffer gives `rd_hit`=0 and `rd_wait`=0. Lookups leave the memory port unchanged.
- R9: When the newest slot holding bytes of the requested word holds only some of its four bytes, `rd_wait` is 1 and `rd_hit` is 0.
- R10: A store accepted in the same cycle as a drain handshake takes effect, and so does the drain. The drained slot leaves, the new slot drains later in order, and no store is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| st_valid | input | 1 | Store request |
| st_ready | output | 1 | Store accepted this cycle when high with `st_valid` |
| st_addr | input | ADDR_W | Store byte address (low two bits ignored) |
| st_data | input | 32 | Store word |
| st_be | input | 4 | Store byte enables |
| rd_addr | input | ADDR_W | Read lookup byte address |
| rd_hit | output | 1 | Requested word fully buffered |
| rd_wait | output | 1 | Requested word partly buffered; read must wait |
| rd_data | output | 32 | Buffered word for a hit |
| mem_valid | output | 1 | A slot is offered to memory |
| mem_ready | input | 1 | Memory accepts the offered slot |
| mem_addr | output | ADDR_W | Block-aligned address of the offered slot |
| mem_data | output | WORDS*32 | Block data of the offered slot |
| mem_bmask | output | WORDS*4 | Per-byte written mask |
| mem_wmask | output | WORDS | Per-word written mask |

## Verification
Two things can happen in the same cycle: the acceptance of a store that opens a slot, and the drain handshake that retires the oldest slot. The bench provokes this by raising `st_valid` for a fresh block and `mem_ready` on the same clock edge while the buffer is three-quarters full. It then judges the outcome from the later drains, which must come out as the remaining older slots followed by the new one, and from `st_ready` staying high. A second overlap puts a read lookup on the buffer while the memory port is stalled. There the bench checks that the offered slot does not move, and that the newest copy of a word that two slots hold for the same block is the one returned.

// File: rtl/wbuf_pkg.sv
package wbuf_pkg;
    localparam int WORD_BYTES = 4;
    localparam int BYTE_W     = 8;
    localparam int WORD_W     = WORD_BYTES * BYTE_W;
endpackage

// File: rtl/wbuf_tag_cmp.sv
module wbuf_tag_cmp #(
    parameter int N     = 4,
    parameter int TAG_W = 28
) (
    input  logic [N*TAG_W-1:0] tags,
    input  logic [N-1:0]       live,
    input  logic [TAG_W-1:0]   key,
    output logic [N-1:0]       hit
);
    for (genvar i = 0; i < N; i++) begin : g_cmp
        assign hit[i] = live[i] && (tags[i*TAG_W +: TAG_W] == key);
    end
endmodule

// File: rtl/wbuf_fwd.sv
module wbuf_fwd #(
    parameter int N      = 4,
    parameter int WORDS  = 4,
    parameter int PTR_W  = 2,
    parameter int CNT_W  = 3,
    parameter int WIDX_W = 2
) (
    input  logic [N-1:0]                                          hitv,
    input  logic [PTR_W-1:0]                                      head,
    input  logic [CNT_W-1:0]                                      count,
    input  logic [WIDX_W-1:0]                                     widx,
    input  logic [N*WORDS*wbuf_pkg::WORD_W-1:0]                   data_vec,
    input  logic [N*WORDS*wbuf_pkg::WORD_BYTES-1:0]               mask_vec,
    output logic                                                  fwd_hit,
    output logic                                                  fwd_wait,
    output logic [wbuf_pkg::WORD_W-1:0]                           fwd_data
);
    localparam int WB     = wbuf_pkg::WORD_BYTES;
    localparam int DW     = wbuf_pkg::WORD_W;
    localparam int BLK_W  = WORDS * DW;
    localparam int MASK_W = WORDS * WB;

    logic             found;
    logic [PTR_W-1:0] sel;
    logic [PTR_W-1:0] idx;
    logic [WB-1:0]    sel_mask;

    // scan oldest to newest; the newest slot with any byte of the word wins
    always_comb begin
        found = 1'b0;
        sel   = '0;
        idx   = '0;
        for (int k = 0; k < N; k++) begin
            idx = head + PTR_W'(k);
            if ((CNT_W'(k) < count) && hitv[idx]
                && (|mask_vec[int'(idx)*MASK_W + int'(widx)*WB +: WB])) begin
                found = 1'b1;
                sel   = idx;
            end
        end
        sel_mask = mask_vec[int'(sel)*MASK_W + int'(widx)*WB +: WB];
        fwd_hit  = found && (&sel_mask);
        fwd_wait = found && !(&sel_mask);
        fwd_data = data_vec[int'(sel)*BLK_W + int'(widx)*DW +: DW];
    end
endmodule

// File: rtl/merge_wbuf.sv
module merge_wbuf #(
    parameter int ENTRIES = 4,
    parameter int WORDS   = 4,
    parameter int ADDR_W  = 32
) (
    input  logic                                      clk,
    input  logic                                      rst_n,
    input  logic                                      st_valid,
    output logic                                      st_ready,
    input  logic [ADDR_W-1:0]                         st_addr,
    input  logic [wbuf_pkg::WORD_W-1:0]               st_data,
    input  logic [wbuf_pkg::WORD_BYTES-1:0]           st_be,
    input  logic [ADDR_W-1:0]                         rd_addr,
    output logic                                      rd_hit,
    output logic                                      rd_wait,
    output logic [wbuf_pkg::WORD_W-1:0]               rd_data,
    output logic                                      mem_valid,
    input  logic                                      mem_ready,
    output logic [ADDR_W-1:0]                         mem_addr,
    output logic [WORDS*wbuf_pkg::WORD_W-1:0]         mem_data,
    output logic [WORDS*wbuf_pkg::WORD_BYTES-1:0]     mem_bmask,
    output logic [WORDS-1:0]                          mem_wmask
);
    localparam int WB     = wbuf_pkg::WORD_BYTES;
    localparam int BW     = wbuf_pkg::BYTE_W;
    localparam int DW     = wbuf_pkg::WORD_W;
    localparam int BLK_W  = WORDS * DW;
    localparam int MASK_W = WORDS * WB;
    localparam int WIDX_W = $clog2(WORDS);
    localparam int OFF_W  = WIDX_W + $clog2(WB);
    localparam int TAG_W  = ADDR_W - OFF_W;
    localparam int PTR_W  = $clog2(ENTRIES);
    localparam int CNT_W  = PTR_W + 1;

    typedef struct packed {
        logic [TAG_W-1:0]  tag;
        logic [BLK_W-1:0]  data;
        logic [MASK_W-1:0] bmask;
    } slot_t;

    typedef struct packed {
        slot_t [ENTRIES-1:0] slot;
        logic [PTR_W-1:0]    head;
        logic [PTR_W-1:0]    tail;
        logic [CNT_W-1:0]    count;
    } wb_state_t;

    wb_state_t s_d, s_q;

    logic [ENTRIES*TAG_W-1:0]  tag_vec;
    logic [ENTRIES*BLK_W-1:0]  data_vec;
    logic [ENTRIES*MASK_W-1:0] mask_vec;
    logic [ENTRIES-1:0]        live, merge_ok, st_hit, rd_hitv;
    logic [TAG_W-1:0]          st_tag, rd_tag;
    logic [WIDX_W-1:0]         st_widx, rd_widx;
    logic [3:0]                unused_low;
    logic                      pop, st_match, fire, alloc;

    assign st_tag     = st_addr[ADDR_W-1:OFF_W];
    assign rd_tag     = rd_addr[ADDR_W-1:OFF_W];
    assign st_widx    = st_addr[OFF_W-1:OFF_W-WIDX_W];
    assign rd_widx    = rd_addr[OFF_W-1:OFF_W-WIDX_W];
    assign unused_low = {st_addr[1:0], rd_addr[1:0]};

    for (genvar i = 0; i < ENTRIES; i++) begin : g_flat
        assign tag_vec[i*TAG_W +: TAG_W]    = s_q.slot[i].tag;
        assign data_vec[i*BLK_W +: BLK_W]   = s_q.slot[i].data;
        assign mask_vec[i*MASK_W +: MASK_W] = s_q.slot[i].bmask;
        assign live[i]     = {1'b0, PTR_W'(i) - s_q.head} < s_q.count;
        // the slot offered to memory is frozen
        assign merge_ok[i] = live[i] && (s_q.head != PTR_W'(i));
    end

    wbuf_tag_cmp #(.N(ENTRIES), .TAG_W(TAG_W)) u_st_cmp (
        .tags(tag_vec), .live(merge_ok), .key(st_tag), .hit(st_hit)
    );

    wbuf_tag_cmp #(.N(ENTRIES), .TAG_W(TAG_W)) u_rd_cmp (
        .tags(tag_vec), .live(live), .key(rd_tag), .hit(rd_hitv)
    );

    wbuf_fwd #(
        .N(ENTRIES), .WORDS(WORDS), .PTR_W(PTR_W), .CNT_W(CNT_W), .WIDX_W(WIDX_W)
    ) u_fwd (
        .hitv(rd_hitv), .head(s_q.head), .count(s_q.count), .widx(rd_widx),
        .data_vec(data_vec), .mask_vec(mask_vec),
        .fwd_hit(rd_hit), .fwd_wait(rd_wait), .fwd_data(rd_data)
    );

    always_comb begin
        s_d      = s_q;
        pop      = (s_q.count != '0) && mem_ready;
        st_match = |st_hit;
        st_ready = st_match || (s_q.count != CNT_W'(ENTRIES));
        fire     = st_valid && st_ready;
        alloc    = fire && !st_match;

        for (int i = 0; i < ENTRIES; i++) begin
            if ((fire && st_hit[i]) || (alloc && (s_q.tail == PTR_W'(i)))) begin
                if (alloc) begin
                    s_d.slot[i].tag   = st_tag;
                    s_d.slot[i].data  = '0;
                    s_d.slot[i].bmask = '0;
                end
                for (int b = 0; b < WB; b++) begin
                    if (st_be[b]) begin
                        s_d.slot[i].data[int'(st_widx)*DW + b*BW +: BW] = st_data[b*BW +: BW];
                        s_d.slot[i].bmask[int'(st_widx)*WB + b]         = 1'b1;
                    end
                end
            end
        end

        if (alloc) s_d.tail = s_q.tail + 1'b1;
        if (pop)   s_d.head = s_q.head + 1'b1;
        s_d.count = s_q.count + CNT_W'(alloc) - CNT_W'(pop);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign mem_valid = (s_q.count != '0);
    assign mem_addr  = {s_q.slot[s_q.head].tag, {OFF_W{1'b0}}};
    assign mem_data  = s_q.slot[s_q.head].data;
    assign mem_bmask = s_q.slot[s_q.head].bmask;

    for (genvar w = 0; w < WORDS; w++) begin : g_wmask
        assign mem_wmask[w] = |mem_bmask[w*WB +: WB];
    end
endmodule

// File: rtl/merge_wbuf_chk.sv
module merge_wbuf_chk #(
    parameter int ADDR_W = 32,
    parameter int BLK_W  = 128,
    parameter int MASK_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              st_valid,
    input logic              st_ready,
    input logic              mem_valid,
    input logic              mem_ready,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [BLK_W-1:0]  mem_data,
    input logic [MASK_W-1:0] mem_bmask,
    input logic              rd_hit,
    input logic              rd_wait
);
    p_reset_empty_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (st_ready && !mem_valid));

    p_drain_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr)
                                       && $stable(mem_data) && $stable(mem_bmask)));

    p_stall_only_full_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_valid && !st_ready) |-> mem_valid);

    p_empty_no_stall_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_valid |-> st_ready);

    p_read_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_hit && rd_wait));
endmodule

bind merge_wbuf merge_wbuf_chk #(
    .ADDR_W(ADDR_W), .BLK_W(WORDS*32), .MASK_W(WORDS*4)
) u_chk (
    .clk(clk), .rst_n(rst_n), .st_valid(st_valid), .st_ready(st_ready),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_addr(mem_addr),
    .mem_data(mem_data), .mem_bmask(mem_bmask), .rd_hit(rd_hit), .rd_wait(rd_wait)
);

// File: tb/merge_wbuf_test.sv
module merge_wbuf_test;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         st_valid = 1'b0;
    logic         st_ready;
    logic [31:0]  st_addr = '0;
    logic [31:0]  st_data = '0;
    logic [3:0]   st_be = '0;
    logic [31:0]  rd_addr = '0;
    logic         rd_hit, rd_wait;
    logic [31:0]  rd_data;
    logic         mem_valid;
    logic         mem_ready = 1'b0;
    logic [31:0]  mem_addr;
    logic [127:0] mem_data;
    logic [15:0]  mem_bmask;
    logic [3:0]   mem_wmask;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    merge_wbuf uut (
        .clk(clk), .rst_n(rst_n), .st_valid(st_valid), .st_ready(st_ready),
        .st_addr(st_addr), .st_data(st_data), .st_be(st_be), .rd_addr(rd_addr),
        .rd_hit(rd_hit), .rd_wait(rd_wait), .rd_data(rd_data),
        .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_addr(mem_addr),
        .mem_data(mem_data), .mem_bmask(mem_bmask), .mem_wmask(mem_wmask)
    );

    task automatic chk(input bit ok, input string req, input logic [127:0] act,
                       input logic [127:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    // called at a negedge; returns at a later negedge with the store accepted
    task automatic store(input logic [31:0] a, input logic [31:0] d, input logic [3:0] be);
        st_addr = a; st_data = d; st_be = be; st_valid = 1'b1;
        #1;
        while (!st_ready) begin
            @(negedge clk);
            #1;
        end
        @(negedge clk);
        st_valid = 1'b0;
    endtask

    task automatic drain(input string req, input logic [31:0] a, input logic [3:0] wm,
                         input logic [15:0] bm, input logic [127:0] d);
        chk(mem_valid == 1'b1, req, mem_valid, 1);
        chk(mem_addr == a, req, mem_addr, a);
        chk(mem_wmask == wm, req, mem_wmask, wm);
        chk(mem_bmask == bm, req, mem_bmask, bm);
        chk(mem_data == d, req, mem_data, d);
        mem_ready = 1'b1;
        @(negedge clk);
        mem_ready = 1'b0;
    endtask

    task automatic t_reset;
        chk(st_ready == 1'b1, "R1", st_ready, 1);
        chk(mem_valid == 1'b0, "R1", mem_valid, 0);
        chk(rd_hit == 1'b0, "R1", rd_hit, 0);
        chk(rd_wait == 1'b0, "R1", rd_wait, 0);
    endtask

    // R2 allocation, R4 no merge into offered slot, R5 order and hold
    task automatic t_alloc_order;
        store(32'h100, 32'hA0, 4'hF);
        store(32'h204, 32'hB1, 4'hF);
        store(32'h108, 32'hA2, 4'hF);
        repeat (3) @(negedge clk);
        chk(mem_valid && mem_addr == 32'h100, "R5 hold", mem_addr, 32'h100);
        drain("R2", 32'h100, 4'b0001, 16'h000F, {32'h0, 32'h0, 32'h0, 32'hA0});
        drain("R5", 32'h200, 4'b0010, 16'h00F0, {32'h0, 32'h0, 32'hB1, 32'h0});
        drain("R4", 32'h100, 4'b0100, 16'h0F00, {32'h0, 32'hA2, 32'h0, 32'h0});
        chk(mem_valid == 1'b0, "R5 empty", mem_valid, 0);
    endtask

    // R3 merge and overwrite, R6 field positions and partial bytes
    task automatic t_merge;
        store(32'h300, 32'hC0, 4'hF);
        store(32'h400, 32'h11110000, 4'hF);
        store(32'h404, 32'h22220001, 4'hF);
        store(32'h408, 32'h33330002, 4'hF);
        store(32'h40C, 32'h44440003, 4'hF);
        store(32'h404, 32'h99998888, 4'b0011);
        store(32'h418, 32'hAABBCCDD, 4'b0100);
        drain("R2", 32'h300, 4'b0001, 16'h000F, {32'h0, 32'h0, 32'h0, 32'hC0});
        drain("R3", 32'h400, 4'b1111, 16'hFFFF,
              {32'h44440003, 32'h33330002, 32'h22228888, 32'h11110000});
        drain("R6", 32'h410, 4'b0100, 16'h0400, {32'h0, 32'h00BB0000, 32'h0, 32'h0});
        chk(mem_valid == 1'b0, "R3 one drain", mem_valid, 0);
    endtask

    // R7 full stall and merge while full, R10 store and drain in one cycle
    task automatic t_full_overlap;
        store(32'h1000, 32'hF0, 4'hF);
        store(32'h2000, 32'hF1, 4'hF);
        store(32'h3000, 32'hF2, 4'hF);
        store(32'h4000, 32'hF3, 4'hF);
        st_addr = 32'h5000; st_data = 32'h50; st_be = 4'hF; st_valid = 1'b1;
        #1;
        chk(st_ready == 1'b0, "R7 stall", st_ready, 0);
        @(negedge clk);
        #1;
        chk(st_ready == 1'b0, "R7 stall held", st_ready, 0);
        chk(mem_addr == 32'h1000, "R7 head", mem_addr, 32'h1000);
        st_addr = 32'h3004; st_data = 32'hF21;
        #1;
        chk(st_ready == 1'b1, "R7 merge when full", st_ready, 1);
        @(negedge clk);
        st_valid = 1'b0;
        drain("R5", 32'h1000, 4'b0001, 16'h000F, {96'h0, 32'hF0});
        st_addr = 32'h5000; st_data = 32'h50; st_be = 4'hF; st_valid = 1'b1;
        mem_ready = 1'b1;
        #1;
        chk(st_ready == 1'b1, "R10 accept", st_ready, 1);
        chk(mem_addr == 32'h2000, "R10 drain", mem_addr, 32'h2000);
        @(negedge clk);
        st_valid = 1'b0;
        mem_ready = 1'b0;
        #1;
        chk(st_ready == 1'b1, "R10 not full", st_ready, 1);
        drain("R7", 32'h3000, 4'b0011, 16'h00FF, {32'h0, 32'h0, 32'hF21, 32'hF2});
        drain("R10", 32'h4000, 4'b0001, 16'h000F, {96'h0, 32'hF3});
        drain("R10", 32'h5000, 4'b0001, 16'h000F, {96'h0, 32'h50});
        chk(mem_valid == 1'b0, "R10 empty", mem_valid, 0);
    endtask

    // R8 forwarding from the newest copy, R9 partial word wait
    task automatic t_read;
        store(32'h7004, 32'hCAFE0001, 4'hF);
        store(32'h7004, 32'h0000BEEF, 4'b0011);
        rd_addr = 32'h7004;
        #1;
        chk(rd_wait == 1'b1, "R9 wait", rd_wait, 1);
        chk(rd_hit == 1'b0, "R9 no hit", rd_hit, 0);
        rd_addr = 32'h7008;
        #1;
        chk(!rd_hit && !rd_wait, "R8 miss", {rd_hit, rd_wait}, 0);
        @(negedge clk);
        store(32'h7004, 32'h12340000, 4'b1100);
        rd_addr = 32'h7004;
        #1;
        chk(rd_hit == 1'b1, "R8 hit", rd_hit, 1);
        chk(rd_data == 32'h1234BEEF, "R8 newest data", rd_data, 32'h1234BEEF);
        @(negedge clk);
        store(32'h800C, 32'h55AA55AA, 4'hF);
        rd_addr = 32'h800C;
        #1;
        chk(rd_hit && rd_data == 32'h55AA55AA, "R8 hit word3", rd_data, 32'h55AA55AA);
        chk(mem_valid && mem_addr == 32'h7000, "R8 port untouched", mem_addr, 32'h7000);
        @(negedge clk);
        drain("R4", 32'h7000, 4'b0010, 16'h00F0, {32'h0, 32'h0, 32'hCAFE0001, 32'h0});
        drain("R8", 32'h7000, 4'b0010, 16'h00F0, {32'h0, 32'h0, 32'h1234BEEF, 32'h0});
        drain("R8", 32'h8000, 4'b1000, 16'hF000, {32'h55AA55AA, 96'h0});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_alloc_order();
        t_merge();
        t_full_overlap();
        t_read();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog act=running exp=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule